// File: doc/BRIEF.md
# Low-Power Mode Controller

This block puts a small processor into one of two sleep depths and brings it back out. Software asks for sleep through two request strobes taken from status-word bits. In the light sleep, IDLE, the core clock stops while the oscillator and timer 0 keep running. In the deep sleep, HALT, the core clock, the timer clock and the oscillator all stop. The block only drives clock and oscillator enables, so RAM, register and I/O contents are kept through either sleep. Only RESET clears any state.

A HALT-enable register decides whether a HALT request is honoured. It clears on reset, and software can load it once after each reset. IDLE ends on NMI or on a timer-0 overflow, and the core clock comes back on the next cycle. HALT ends only on NMI or RESET. After an NMI in HALT, the oscillator restarts first, and the core clock stays off until the oscillator reports that it is stable. When an NMI ends a sleep, the block raises a one-cycle strobe that starts the vectored interrupt in the core. A two-bit code tells software what ended the last sleep.

Top module: `lpm_ctrl`

## Requirements
- R1: When `reqHalt` is sampled high in the running state and the HALT-enable register holds 1, the block enters HALT. In HALT, `cpuClkEn`, `tmrClkEn` and `oscEn` are all 0 from the next cycle on.
- R2: When `reqIdle` is sampled high in the running state and no HALT is taken, the block enters IDLE. In IDLE, `cpuClkEn` is 0 and both `tmrClkEn` and `oscEn` are 1.
- R3: A `reqHalt` sampled while the HALT-enable register holds 0 has no effect: all three enables stay 1.
- R4: In IDLE, `t0Ovf` sampled high without `nmiIn` returns the block to running on the next cycle. `wakeCause` becomes 2'b10 and `nmiStart` stays 0.
- R5: `wakeCause` encodings are 2'b00 for reset, 2'b01 for NMI, 2'b10 for timer overflow and 2'b11 while asleep with no wake yet. The code is set to 2'b11 on sleep entry and then holds its value until the next sleep entry.
- R6: The HALT-enable register is 0 after reset and is shown on `haltEnOut`. The first cycle with `henWrEn` high loads `henWrData`. Every later write before the next reset is ignored.
- R7: In HALT, `t0Ovf` is ignored and all enables stay 0.
- R8: In HALT, `nmiIn` sampled high turns `oscEn` on at once and sets `wakeCause` to 2'b01, while `cpuClkEn` and `tmrClkEn` stay 0. The block returns to running only at a later edge where `oscStable` is sampled high.
- R9: `nmiStart` is high for exactly one cycle: the first running cycle after an NMI wake from either sleep depth. It is never high after a timer wake.
- R10: In IDLE, `nmiIn` returns the block to running on the next cycle with no stabilization wait. If `nmiIn` and `t0Ovf` are sampled together, NMI wins.
- R11: If `reqHalt` and `reqIdle` are sampled together while HALT is enabled, the block enters HALT.
- R12: Asserting `rstN` low returns the block to running at once from any state, with `wakeCause` at 2'b00 and the HALT-enable register cleared and open to one new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| rstN | input | 1 | Asynchronous active-low RESET |
| reqHalt | input | 1 | Software HALT request strobe |
| reqIdle | input | 1 | Software IDLE request strobe |
| henWrEn | input | 1 | Write strobe for the HALT-enable register |
| henWrData | input | 1 | Value written to the HALT-enable register |
| nmiIn | input | 1 | Non-maskable interrupt event |
| t0Ovf | input | 1 | Timer-0 overflow event |
| oscStable | input | 1 | Oscillator reports stable output |
| cpuClkEn | output | 1 | Core clock enable |
| tmrClkEn | output | 1 | Timer-0 clock enable |
| oscEn | output | 1 | Oscillator enable |
| wakeCause | output | 2 | Cause of the last wake (see R5) |
| nmiStart | output | 1 | One-cycle start of the vectored NMI |
| haltEnOut | output | 1 | Current HALT-enable register value |

## Verification
The sleep state can be read directly from the three enables. A wrong state transition therefore shows on the first cycle after the edge that should have caused the change, and on no later cycle. A lost write lock, or a lock set at the wrong time, shows on `haltEnOut` one cycle after the write that should have been refused. A stabilization wait that ends too early shows as `cpuClkEn` rising in the same cycle `oscEn` rises. A wake-cause register with a wrong hold or load shows in the run cycles that follow a wake, where `wakeCause` must stay unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_HALT = 2'd2,
    ST_STAB = 2'd3
  } lpm_state_e;

  typedef enum logic [1:0] {
    CAUSE_RST   = 2'b00,
    CAUSE_NMI   = 2'b01,
    CAUSE_TMR   = 2'b10,
    CAUSE_SLEEP = 2'b11
  } wake_cause_e;

  // control -> datapath strobes
  typedef struct packed {
    logic        causeLd;
    wake_cause_e causeVal;
    logic        nmiFire;
    logic        stabRun;
  } lpm_strobe_t;

endpackage

// File: rtl/lpm_dp.sv
module lpm_dp
  import lpm_pkg::*;
#(
  parameter int STAB_MODE   = 0,  // 0: wait on oscStable, 1: fixed count
  parameter int STAB_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  lpm_strobe_t strb,
  input  logic        henWrEn,
  input  logic        henWrData,
  input  logic        oscStable,
  output logic        haltEn,
  output logic        stabDone,
  output wake_cause_e causeQ,
  output logic        nmiStartQ
);

  localparam int CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES + 1) : 1;

  logic henReg;
  logic henLocked;

  // write-once enable register, re-armed only by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      henReg    <= 1'b0;
      henLocked <= 1'b0;
    end else if (henWrEn && !henLocked) begin
      henReg    <= henWrData;
      henLocked <= 1'b1;
    end
  end

  assign haltEn = henReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ    <= CAUSE_RST;
      nmiStartQ <= 1'b0;
    end else begin
      if (strb.causeLd) causeQ <= strb.causeVal;
      nmiStartQ <= strb.nmiFire;
    end
  end

  generate
    if (STAB_MODE == 0) begin : g_stab_input
      assign stabDone = strb.stabRun && oscStable;
    end else begin : g_stab_count
      logic [CNT_W-1:0] stabCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             stabCnt <= '0;
        else if (!strb.stabRun) stabCnt <= '0;
        else if (!stabDone)     stabCnt <= stabCnt + 1'b1;
      end
      assign stabDone = strb.stabRun &&
                        (stabCnt == CNT_W'(STAB_CYCLES - 1));
    end
  endgenerate

endmodule

// File: rtl/lpm_ctl.sv
module lpm_ctl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqHalt,
  input  logic        reqIdle,
  input  logic        nmiIn,
  input  logic        t0Ovf,
  input  logic        haltEn,
  input  logic        stabDone,
  output lpm_strobe_t strb,
  output logic        cpuClkEn,
  output logic        tmrClkEn,
  output logic        oscEn
);

  lpm_state_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD        = stateQ;
    strb.causeLd  = 1'b0;
    strb.causeVal = CAUSE_SLEEP;
    strb.nmiFire  = 1'b0;
    strb.stabRun  = 1'b0;
    unique case (stateQ)
      ST_RUN: begin
        if (reqHalt && haltEn) begin
          stateD       = ST_HALT;
          strb.causeLd = 1'b1;
        end else if (reqIdle) begin
          stateD       = ST_IDLE;
          strb.causeLd = 1'b1;
        end
      end
      ST_IDLE: begin
        if (nmiIn) begin
          stateD        = ST_RUN;
          strb.causeLd  = 1'b1;
          strb.causeVal = CAUSE_NMI;
          strb.nmiFire  = 1'b1;
        end else if (t0Ovf) begin
          stateD        = ST_RUN;
          strb.causeLd  = 1'b1;
          strb.causeVal = CAUSE_TMR;
        end
      end
      ST_HALT: begin
        if (nmiIn) begin
          stateD        = ST_STAB;
          strb.causeLd  = 1'b1;
          strb.causeVal = CAUSE_NMI;
        end
      end
      ST_STAB: begin
        strb.stabRun = 1'b1;
        if (stabDone) begin
          stateD       = ST_RUN;
          strb.nmiFire = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  assign cpuClkEn = (stateQ == ST_RUN);
  assign tmrClkEn = (stateQ == ST_RUN) || (stateQ == ST_IDLE);
  assign oscEn    = (stateQ != ST_HALT);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int STAB_MODE   = 0,
  parameter int STAB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqHalt,
  input  logic       reqIdle,
  input  logic       henWrEn,
  input  logic       henWrData,
  input  logic       nmiIn,
  input  logic       t0Ovf,
  input  logic       oscStable,
  output logic       cpuClkEn,
  output logic       tmrClkEn,
  output logic       oscEn,
  output logic [1:0] wakeCause,
  output logic       nmiStart,
  output logic       haltEnOut
);

  lpm_strobe_t strb;
  logic        haltEn;
  logic        stabDone;
  wake_cause_e causeQ;

  lpm_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqHalt  (reqHalt),
    .reqIdle  (reqIdle),
    .nmiIn    (nmiIn),
    .t0Ovf    (t0Ovf),
    .haltEn   (haltEn),
    .stabDone (stabDone),
    .strb     (strb),
    .cpuClkEn (cpuClkEn),
    .tmrClkEn (tmrClkEn),
    .oscEn    (oscEn)
  );

  lpm_dp #(
    .STAB_MODE   (STAB_MODE),
    .STAB_CYCLES (STAB_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .henWrEn   (henWrEn),
    .henWrData (henWrData),
    .oscStable (oscStable),
    .haltEn    (haltEn),
    .stabDone  (stabDone),
    .causeQ    (causeQ),
    .nmiStartQ (nmiStart)
  );

  assign wakeCause = causeQ;
  assign haltEnOut = haltEn;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       henWrEn,
  input logic       cpuClkEn,
  input logic       tmrClkEn,
  input logic       oscEn,
  input logic [1:0] wakeCause,
  input logic       nmiStart,
  input logic       haltEnOut
);

  logic seenWr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenWr <= 1'b0;
    else if (henWrEn) seenWr <= 1'b1;
  end

  AST_HALT_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!cpuClkEn && !tmrClkEn));                       // R1
  AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> (tmrClkEn && oscEn));                          // R2
  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (wakeCause == 2'b11));                           // R5
  AST_HEN_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    seenWr |=> $stable(haltEnOut));                             // R6
  AST_HALT_NO_DIRECT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |=> !cpuClkEn);                                      // R8
  AST_STAB_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (oscEn && !tmrClkEn) |-> (wakeCause == 2'b01));             // R8
  AST_NMI_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    nmiStart |-> (cpuClkEn && wakeCause == 2'b01));             // R9
  AST_NMI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    nmiStart |=> !nmiStart);                                    // R9

endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .henWrEn   (henWrEn),
  .cpuClkEn  (cpuClkEn),
  .tmrClkEn  (tmrClkEn),
  .oscEn     (oscEn),
  .wakeCause (wakeCause),
  .nmiStart  (nmiStart),
  .haltEnOut (haltEnOut)
);

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqHalt = 1'b0, reqIdle = 1'b0, henWrEn = 1'b0, henWrData = 1'b0;
  logic       nmiIn = 1'b0, t0Ovf = 1'b0, oscStable = 1'b0;
  logic       cpuClkEn, tmrClkEn, oscEn, nmiStart, haltEnOut;
  logic [1:0] wakeCause;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpm_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqHalt(reqHalt), .reqIdle(reqIdle),
    .henWrEn(henWrEn), .henWrData(henWrData), .nmiIn(nmiIn), .t0Ovf(t0Ovf),
    .oscStable(oscStable), .cpuClkEn(cpuClkEn), .tmrClkEn(tmrClkEn),
    .oscEn(oscEn), .wakeCause(wakeCause), .nmiStart(nmiStart),
    .haltEnOut(haltEnOut)
  );

  // stimulus {reqHalt reqIdle henWrEn henWrData nmiIn t0Ovf oscStable}
  // expected {cpuClkEn tmrClkEn oscEn wakeCause[1:0] nmiStart haltEnOut}
  // requirement number
  localparam logic [17:0] VEC [NVEC] = '{
    {7'b1000000, 7'b1110000, 4'd3},   // R3 halt while disabled
    {7'b0100000, 7'b0111100, 4'd2},   // R2 enter idle
    {7'b0000010, 7'b1111000, 4'd4},   // R4 timer wake
    {7'b0011000, 7'b1111001, 4'd6},   // R6 first write
    {7'b0010000, 7'b1111001, 4'd6},   // R6 second write ignored
    {7'b1000000, 7'b0001101, 4'd1},   // R1 enter halt
    {7'b0000010, 7'b0001101, 4'd7},   // R7 timer ignored in halt
    {7'b0000100, 7'b0010101, 4'd8},   // R8 nmi starts oscillator
    {7'b0000000, 7'b0010101, 4'd8},   // R8 still waiting
    {7'b0000001, 7'b1110111, 4'd9},   // R9 stable -> run, nmi strobe
    {7'b0100000, 7'b0111101, 4'd2},   // R2 idle again
    {7'b0000110, 7'b1110111, 4'd10},  // R10 nmi beats timer, no wait
    {7'b1100000, 7'b0001101, 4'd11},  // R11 halt wins
    {7'b0000101, 7'b0010101, 4'd8},   // R8 stable early still waits a cycle
    {7'b0000001, 7'b1110111, 4'd8},   // R8 wake completes
    {7'b0000000, 7'b1110101, 4'd5}    // R5 cause held, strobe gone
  };

  function automatic logic [6:0] sample();
    return {cpuClkEn, tmrClkEn, oscEn, wakeCause, nmiStart, haltEnOut};
  endfunction

  task automatic check(input logic [6:0] exp, input int req, input string what);
    total++;
    if (sample() !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, sample(), exp);
    end
  endtask

  task automatic drive(input logic [6:0] s);
    {reqHalt, reqIdle, henWrEn, henWrData, nmiIn, t0Ovf, oscStable} = s;
    @(posedge clk);
    @(negedge clk);
    {reqHalt, reqIdle, henWrEn, henWrData, nmiIn, t0Ovf, oscStable} = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(7'b1110000, 12, "reset state");             // R12
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][17:11]);
      check(VEC[i][10:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end
    // R12: reset during halt, then write-once re-armed
    drive(7'b1000000);
    check(7'b0001101, 1, "halt before reset");        // R1
    rstN = 1'b0;
    #1;
    check(7'b1110000, 12, "async reset from halt");   // R12
    @(negedge clk);
    rstN = 1'b1;
    drive(7'b0010000);
    check(7'b1110000, 12, "write 0 after reset");     // R12
    drive(7'b0011000);
    check(7'b1110000, 6, "later write of 1 ignored"); // R6
    drive(7'b1000000);
    check(7'b1110000, 3, "halt still disabled");      // R3
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule